// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces operand addresses for delay lines, filter histories and FFT data sets. It keeps two banks (primary and secondary) of eight register sets each. A set has four registers: index, modify, base and length. On each access strobe the block drives an address taken from the index of the selected set. It then post-modifies that index by the modify value. In circular mode the new index is folded back into the window [base, base + length), so a buffer may start at any address and have any length. In bit-reverse mode the lowest N bits of the index are mirrored on the address, which gives the shuffled order an FFT needs.

A processor's operand path drives the set select, the mode and the strobe every cycle. One address can come out per cycle. Software loads the registers through a single write port that targets the active bank. A bank-select level makes the other bank active in a single step, so an interrupt handler can get fresh pointers without saving the old ones.

Top module: `cbuf_agen`

## Requirements
- R1: After reset every register in both banks is zero and the primary bank (bank_sel value 0) is active, so an access to any set gives address 0 and updated index 0.
- R2: A write with wr_en high loads wr_data into the register named by wr_reg (0 index, 1 modify, 2 base, 3 length) of set wr_sel in the active bank, and a later access returns the written index as its address.
- R3: In linear mode (mode 0, and also mode 3) an access drives addr equal to the current index and idx_next equal to index plus modify, with modify taken as two's complement; the next access to that set starts from idx_next.
- R4: In circular mode (mode 1) with a nonzero length, a sum index plus modify that is equal to or above base plus length has length subtracted, for any base alignment.
- R5: In circular mode with a nonzero length, a sum below base has length added.
- R6: In circular mode with a length of zero, the post-modify is plain linear.
- R7: In bit-reverse mode (mode 2) addr is the index with its lowest N bits mirrored (bit i takes bit N-1-i), where N is brev_n in the range 1 to 16; the upper bits pass through unchanged, and the index is post-modified linearly.
- R8: The active bank follows the bank_sel level with one cycle of delay: an access in the same cycle as a change still uses the old bank. Register contents of both banks are kept across swaps.
- R9: When a write to the index of a set and an access to the same set fall in the same cycle, the access uses the old index, and the written value, not the post-modified one, is what the next access sees.
- R10: An access changes only the index of the selected set in the active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc | input | 1 | Access strobe |
| sel | input | 3 | Register set used by the access |
| mode | input | 2 | 0 linear, 1 circular, 2 bit-reverse, 3 linear |
| brev_n | input | 5 | Number of low bits mirrored in bit-reverse mode (1 to 16) |
| bank_sel | input | 1 | Requested bank: 0 primary, 1 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register set written |
| wr_reg | input | 2 | Register written: 0 index, 1 modify, 2 base, 3 length |
| wr_data | input | 32 | Write data |
| addr | output | 32 | Generated address |
| idx_next | output | 32 | Post-modified index that the access stores |

## Verification
Address and updated index are combinational functions of the registered set contents. They are due in the same cycle as the strobe, so the bench drives inputs on the falling edge and samples both outputs shortly after, before the next rising edge. The stored index, a register write and a bank change all take effect at the following rising edge. The bench observes them one access later: it starts that access on the next falling edge and reads the address it produces. The collision and bank-swap cases check the old value in the first cycle and the new value in the next one.

// File: rtl/cbuf_agen.sv
module cbuf_agen #(
  parameter int AW    = 32,
  parameter int NSETS = 8,
  parameter int BRW   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc,
  input  logic [$clog2(NSETS)-1:0]   sel,
  input  logic [1:0]                 mode,
  input  logic [$clog2(BRW+1)-1:0]   brev_n,
  input  logic                       bank_sel,
  input  logic                       wr_en,
  input  logic [$clog2(NSETS)-1:0]   wr_sel,
  input  logic [1:0]                 wr_reg,
  input  logic [AW-1:0]              wr_data,
  output logic [AW-1:0]              addr,
  output logic [AW-1:0]              idx_next
);
  localparam int SW = $clog2(NSETS);
  localparam int NR = 2 * NSETS;
  localparam int EW = AW + 2;

  logic [AW-1:0] idx_r [NR];
  logic [AW-1:0] mod_r [NR];
  logic [AW-1:0] bas_r [NR];
  logic [AW-1:0] len_r [NR];
  logic          bank_q;

  logic [SW:0] rd_ptr, wr_ptr;
  assign rd_ptr = {bank_q, sel};
  assign wr_ptr = {bank_q, wr_sel};

  logic [AW-1:0] cur_idx, cur_mod, cur_base, cur_len;
  assign cur_idx  = idx_r[rd_ptr];
  assign cur_mod  = mod_r[rd_ptr];
  assign cur_base = bas_r[rd_ptr];
  assign cur_len  = len_r[rd_ptr];

  logic signed [EW-1:0] sum, lo, hi, wrapped;
  assign sum = signed'({2'b00, cur_idx}) + signed'({{2{cur_mod[AW-1]}}, cur_mod});
  assign lo  = signed'({2'b00, cur_base});
  assign hi  = lo + signed'({2'b00, cur_len});

  always_comb begin
    wrapped = sum;
    if (mode == 2'd1 && cur_len != '0) begin
      if (sum >= hi)     wrapped = sum - signed'({2'b00, cur_len});
      else if (sum < lo) wrapped = sum + signed'({2'b00, cur_len});
    end
  end
  assign idx_next = wrapped[AW-1:0];

  logic [AW-1:0] rev;
  always_comb begin
    int n;
    n = (int'(brev_n) > BRW) ? BRW : int'(brev_n);
    rev = cur_idx;
    for (int i = 0; i < BRW; i++)
      for (int j = 0; j < BRW; j++)
        if (i < n && j == n - 1 - i) rev[i] = cur_idx[j];
  end
  assign addr = (mode == 2'd2) ? rev : cur_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      for (int k = 0; k < NR; k++) begin
        idx_r[k] <= '0;
        mod_r[k] <= '0;
        bas_r[k] <= '0;
        len_r[k] <= '0;
      end
    end else begin
      bank_q <= bank_sel;
      if (acc) idx_r[rd_ptr] <= idx_next;
      if (wr_en) begin
        case (wr_reg)
          2'd0:    idx_r[wr_ptr] <= wr_data;
          2'd1:    mod_r[wr_ptr] <= wr_data;
          2'd2:    bas_r[wr_ptr] <= wr_data;
          default: len_r[wr_ptr] <= wr_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
  parameter int AW    = 32,
  parameter int NSETS = 8,
  parameter int BRW   = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     acc,
  input logic [$clog2(NSETS)-1:0] sel,
  input logic [1:0]               mode,
  input logic                     bank_sel,
  input logic                     bank_q,
  input logic                     wr_en,
  input logic [$clog2(NSETS)-1:0] wr_sel,
  input logic [1:0]               wr_reg,
  input logic [AW-1:0]            wr_data,
  input logic [AW-1:0]            addr,
  input logic [AW-1:0]            idx_next,
  input logic [AW-1:0]            cur_idx,
  input logic [AW-1:0]            cur_mod,
  input logic [AW-1:0]            cur_base,
  input logic [AW-1:0]            cur_len
);
  logic [AW:0]   off_cur, off_nxt, top;
  logic [AW-1:0] mag;
  logic          cur_in, nxt_in, idx_hit;
  assign off_cur = {1'b0, cur_idx}  - {1'b0, cur_base};
  assign off_nxt = {1'b0, idx_next} - {1'b0, cur_base};
  assign top     = {1'b0, cur_base} + {1'b0, cur_len};
  assign mag     = cur_mod[AW-1] ? (~cur_mod + 1'b1) : cur_mod;
  assign cur_in  = (cur_idx  >= cur_base) && (off_cur < {1'b0, cur_len});
  assign nxt_in  = (idx_next >= cur_base) && (off_nxt < {1'b0, cur_len});
  assign idx_hit = wr_en && wr_reg == 2'd0 && wr_sel == sel;

  assert_addr_is_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode != 2'd2) |-> addr == cur_idx);

  assert_postmod_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !idx_hit && bank_sel == bank_q) |=> (sel != $past(sel) || cur_idx == $past(idx_next)));

  assert_wrap_stays_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'd1 && cur_len != '0 && !top[AW] && cur_in && mag <= cur_len) |-> nxt_in);

  assert_len_zero_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'd1 && cur_len == '0) |-> idx_next == cur_idx + cur_mod);

  assert_brev_keeps_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'd2) |-> $countones(addr) == $countones(cur_idx));

  assert_write_beats_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_hit && bank_sel == bank_q) |=> (sel != $past(sel) || cur_idx == $past(wr_data)));
endmodule

bind cbuf_agen cbuf_agen_chk #(.AW(AW), .NSETS(NSETS), .BRW(BRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .sel(sel), .mode(mode),
  .bank_sel(bank_sel), .bank_q(bank_q), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_reg(wr_reg), .wr_data(wr_data), .addr(addr), .idx_next(idx_next),
  .cur_idx(cur_idx), .cur_mod(cur_mod), .cur_base(cur_base), .cur_len(cur_len)
);

// File: tb/tb_cbuf_agen.sv
module tb_cbuf_agen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc = 1'b0;
  logic [2:0]  sel = '0;
  logic [1:0]  mode = '0;
  logic [4:0]  brev_n = 5'd1;
  logic        bank_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [1:0]  wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] addr, idx_next;

  int checks = 0;
  int fails = 0;

  cbuf_agen dut (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sel(sel), .mode(mode), .brev_n(brev_n),
    .bank_sel(bank_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_reg(wr_reg),
    .wr_data(wr_data), .addr(addr), .idx_next(idx_next)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] r, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_reg = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [2:0] s, input logic [31:0] i, input logic [31:0] m,
                      input logic [31:0] b, input logic [31:0] l);
    wr(s, 2'd0, i); wr(s, 2'd1, m); wr(s, 2'd2, b); wr(s, 2'd3, l);
  endtask

  task automatic access(input string tag, input logic [2:0] s, input logic [1:0] md,
                        input logic [31:0] ea, input logic [31:0] en);
    acc = 1'b1; sel = s; mode = md;
    #1;
    check({tag, " addr"}, addr, ea);
    check({tag, " idx_next"}, idx_next, en);
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic t_reset;
    access("R1 reset set0", 3'd0, 2'd0, 32'd0, 32'd0);
    access("R1 reset set7", 3'd7, 2'd1, 32'd0, 32'd0);
  endtask

  task automatic t_linear;
    load(3'd1, 32'd100, 32'd3, 32'd0, 32'd0);
    access("R2 R3 linear first", 3'd1, 2'd0, 32'd100, 32'd103);
    access("R3 linear second", 3'd1, 2'd3, 32'd103, 32'd106);
    wr(3'd1, 2'd1, -32'sd8);
    access("R3 negative modify", 3'd1, 2'd0, 32'd106, 32'd98);
  endtask

  task automatic t_circular;
    load(3'd2, 32'd1006, 32'd3, 32'd1001, 32'd7);
    access("R4 wrap above end", 3'd2, 2'd1, 32'd1006, 32'd1002);
    wr(3'd2, 2'd1, -32'sd4);
    access("R5 wrap below base", 3'd2, 2'd1, 32'd1002, 32'd1005);
    wr(3'd2, 2'd1, 32'd3);
    access("R4 sum equals end", 3'd2, 2'd1, 32'd1005, 32'd1001);
    access("R4 inside no wrap", 3'd2, 2'd1, 32'd1001, 32'd1004);
  endtask

  task automatic t_len_zero;
    load(3'd3, 32'd60, 32'd10, 32'd50, 32'd0);
    access("R6 length zero", 3'd3, 2'd1, 32'd60, 32'd70);
    access("R6 length zero again", 3'd3, 2'd1, 32'd70, 32'd80);
  endtask

  task automatic t_bitrev;
    load(3'd4, 32'h1234_5601, 32'd4, 32'd0, 32'd0);
    brev_n = 5'd8;
    access("R7 brev 8 bits", 3'd4, 2'd2, 32'h1234_5680, 32'h1234_5605);
    wr(3'd4, 2'd0, 32'h0001_0001);
    brev_n = 5'd16;
    access("R7 brev 16 bits", 3'd4, 2'd2, 32'h0001_8000, 32'h0001_0005);
    brev_n = 5'd1;
    access("R7 brev 1 bit", 3'd4, 2'd2, 32'h0001_0005, 32'h0001_0009);
    brev_n = 5'd3;
    access("R7 brev 3 bits", 3'd4, 2'd2, 32'h0001_000C, 32'h0001_000D);
  endtask

  task automatic t_collision;
    load(3'd5, 32'd10, 32'd1, 32'd0, 32'd0);
    wr_en = 1'b1; wr_sel = 3'd5; wr_reg = 2'd0; wr_data = 32'd40;
    access("R9 access uses old index", 3'd5, 2'd0, 32'd10, 32'd11);
    wr_en = 1'b0;
    access("R9 write wins", 3'd5, 2'd0, 32'd40, 32'd41);
  endtask

  task automatic t_isolation;
    access("R10 set2 untouched", 3'd2, 2'd0, 32'd1004, 32'd1007);
    access("R10 set3 untouched", 3'd3, 2'd0, 32'd80, 32'd90);
  endtask

  task automatic t_bank;
    bank_sel = 1'b1;
    access("R8 old bank same cycle", 3'd1, 2'd0, 32'd98, 32'd90);
    access("R8 secondary empty", 3'd1, 2'd0, 32'd0, 32'd0);
    wr(3'd1, 2'd0, 32'd7);
    access("R8 secondary written", 3'd1, 2'd0, 32'd7, 32'd7);
    bank_sel = 1'b0;
    @(negedge clk);
    access("R8 primary kept", 3'd1, 2'd0, 32'd90, 32'd82);
    bank_sel = 1'b1;
    @(negedge clk);
    access("R8 secondary kept", 3'd1, 2'd0, 32'd7, 32'd7);
    bank_sel = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_linear;
    t_circular;
    t_len_zero;
    t_bitrev;
    t_collision;
    t_isolation;
    t_bank;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule